// File: doc/BRIEF.md
# Register Rename Map Table

This block sits where in-order decode hands instructions to out-of-order execution. Each cycle it accepts at most one decoded instruction and turns its architectural register numbers into physical register numbers. Both source operands are looked up in the current map. If the instruction has a destination, a physical register is taken from a free list and the map entry for that destination is updated, so that later instructions read the new name. Every architectural write gets a physical register that no in-flight instruction uses. Because each physical register has exactly one writer, write-after-write and write-after-read hazards disappear without any comparison logic.

Integer and floating-point registers have separate map tables and separate free lists. A flag on the instruction selects which pool it uses. When the selected free list is empty, the block withdraws its ready signal. The upstream stage keeps the instruction presented until a register comes back through the release port. The release port is the only way registers re-enter a free list. Branch checkpoints are not part of this block.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i of each pool maps to physical register i. The first destinations renamed in a pool receive physical numbers ARCH_REGS, ARCH_REGS+1, ... in increasing order, up to PHYS_REGS-1.
- R2: A source is translated through the map as it stands after every earlier accepted instruction, so it names the physical register allocated to the most recent earlier writer of that architectural register in the same pool.
- R3: When an instruction reads and writes the same architectural register, its source translations use the mapping from before its own destination update.
- R4: An instruction with `in_has_dst` low takes no physical register and leaves the map unchanged, and its `out_phys_dst` reads 0.
- R5: With `in_fp` = 0 the instruction uses the integer pool and with `in_fp` = 1 the floating-point pool. Both sources are looked up in the selected pool. Renaming in one pool never changes the map or free list of the other.
- R6: `in_ready` is low while the free list of the pool selected by `in_fp` is empty, and no instruction is accepted then. A held instruction is accepted once a register of its pool is released, and it receives that register.
- R7: Once a pool's never-used registers are exhausted, released registers are handed out again in the order they were released.
- R8: A release and an allocation in the same pool in the same cycle lose no register. If the free list held entries, the allocation takes the oldest entry and the released register joins the back of the list.
- R9: Results are registered. `out_valid` is high in the cycle after an instruction is accepted (`in_valid` and `in_ready` both high at a rising edge) and low otherwise, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_fp | input | 1 | Pool select: 0 integer, 1 floating point |
| in_src_a | input | $clog2(ARCH_REGS) | First source architectural register |
| in_src_b | input | $clog2(ARCH_REGS) | Second source architectural register |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | $clog2(ARCH_REGS) | Destination architectural register |
| rel_valid | input | 1 | Return a physical register to a free list |
| rel_fp | input | 1 | Pool of the returned register |
| rel_phys | input | $clog2(PHYS_REGS) | Returned physical register |
| out_valid | output | 1 | Renamed instruction valid |
| out_fp | output | 1 | Pool of the renamed instruction |
| out_phys_a | output | $clog2(PHYS_REGS) | Physical name of first source |
| out_phys_b | output | $clog2(PHYS_REGS) | Physical name of second source |
| out_has_dst | output | 1 | Renamed instruction writes a register |
| out_phys_dst | output | $clog2(PHYS_REGS) | Allocated physical destination, 0 if none |

## Verification
Two functions can land in the same cycle: a release and an allocation in the same pool. The bench provokes this in both states of the free list. With the list drained, the instruction must stall in that cycle and then take the just-returned register. With entries left, the allocation must take the oldest entry while the returned one queues behind. Random traffic mixes releases of previously displaced mappings with renames in both pools, so the two functions often coincide. Every output is compared with a bench model built from per-pool map arrays and queue-based free lists.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic {
    POOL_INT = 1'b0,
    POOL_FP  = 1'b1
  } pool_e;

  localparam int NUM_POOLS = 2;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 48,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [PW-1:0] rd_a_phys,
  output logic [PW-1:0] rd_b_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_phys
);
  logic [PW-1:0] map_q [ARCH_REGS];

  // Reads see the table before this cycle's write lands at the edge.
  assign rd_a_phys = map_q[rd_a_idx];
  assign rd_b_phys = map_q[rd_b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_phys;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 48,
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int CW    = $clog2(PHYS_REGS + 1),
  localparam int DEPTH = PHYS_REGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  output logic [PW-1:0] alloc_phys,
  output logic          empty,
  input  logic          rel,
  input  logic [PW-1:0] rel_phys,
  output logic [CW-1:0] recycle_cnt
);
  // Never-used registers come from a counter; returned ones from a FIFO.
  logic [CW-1:0] fresh_q;
  logic          fresh_avail;
  logic [PW-1:0] fifo_mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign fresh_avail = fresh_q < CW'(PHYS_REGS);
  assign empty       = !fresh_avail && (cnt_q == '0);
  assign alloc_phys  = fresh_avail ? fresh_q[PW-1:0] : fifo_mem[rd_ptr_q];
  assign pop         = alloc && !fresh_avail && (cnt_q != '0);
  assign recycle_cnt = cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rel) fifo_mem[wr_ptr_q] <= rel_phys;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q  <= CW'(ARCH_REGS);
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (alloc && fresh_avail) fresh_q <= fresh_q + 1'b1;
      if (pop) rd_ptr_q <= wrap_inc(rd_ptr_q);
      if (rel) wr_ptr_q <= wrap_inc(wr_ptr_q);
      case ({rel, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 48,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_fp,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic          in_has_dst,
  input  logic [AW-1:0] in_dst,
  input  logic          rel_valid,
  input  logic          rel_fp,
  input  logic [PW-1:0] rel_phys,
  output logic          out_valid,
  output logic          out_fp,
  output logic [PW-1:0] out_phys_a,
  output logic [PW-1:0] out_phys_b,
  output logic          out_has_dst,
  output logic [PW-1:0] out_phys_dst
);
  logic [PW-1:0] look_a     [NUM_POOLS];
  logic [PW-1:0] look_b     [NUM_POOLS];
  logic [PW-1:0] alloc_phys [NUM_POOLS];
  logic          pool_empty [NUM_POOLS];
  logic [CW-1:0] pool_cnt   [NUM_POOLS];
  logic          accept;
  pool_e         sel;

  assign sel      = pool_e'(in_fp);
  assign in_ready = !rst && !pool_empty[sel];
  assign accept   = in_valid && in_ready;

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    logic take;
    assign take = accept && in_has_dst && (sel == pool_e'(p));

    rn_map_table #(
      .ARCH_REGS(ARCH_REGS),
      .PHYS_REGS(PHYS_REGS)
    ) u_map (
      .clk      (clk),
      .rst      (rst),
      .rd_a_idx (in_src_a),
      .rd_b_idx (in_src_b),
      .rd_a_phys(look_a[p]),
      .rd_b_phys(look_b[p]),
      .wr_en    (take),
      .wr_idx   (in_dst),
      .wr_phys  (alloc_phys[p])
    );

    rn_free_list #(
      .ARCH_REGS(ARCH_REGS),
      .PHYS_REGS(PHYS_REGS)
    ) u_free (
      .clk        (clk),
      .rst        (rst),
      .alloc      (take),
      .alloc_phys (alloc_phys[p]),
      .empty      (pool_empty[p]),
      .rel        (rel_valid && (pool_e'(rel_fp) == pool_e'(p))),
      .rel_phys   (rel_phys),
      .recycle_cnt(pool_cnt[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_fp       <= 1'b0;
      out_phys_a   <= '0;
      out_phys_b   <= '0;
      out_has_dst  <= 1'b0;
      out_phys_dst <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_fp       <= in_fp;
        out_phys_a   <= look_a[sel];
        out_phys_b   <= look_b[sel];
        out_has_dst  <= in_has_dst;
        out_phys_dst <= in_has_dst ? alloc_phys[sel] : '0;
      end
    end
  end
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int PHYS_REGS = 48,
  localparam int PW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_fp,
  input logic          out_valid,
  input logic          out_fp,
  input logic          out_has_dst,
  input logic [PW-1:0] out_phys_dst,
  input logic          int_empty,
  input logic          fp_empty,
  input logic [CW-1:0] int_cnt,
  input logic [CW-1:0] fp_cnt
);
  AST_OUT_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid && in_ready)); // R9

  AST_STALL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (in_fp ? fp_empty : int_empty) |-> !in_ready); // R6

  AST_NODST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_has_dst) |-> out_phys_dst == '0); // R4

  AST_POOL_TAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_fp == $past(in_fp)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (int_cnt <= CW'(PHYS_REGS)) && (fp_cnt <= CW'(PHYS_REGS))); // R8
endmodule

bind rename_map rename_map_chk #(.PHYS_REGS(PHYS_REGS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_fp       (in_fp),
  .out_valid   (out_valid),
  .out_fp      (out_fp),
  .out_has_dst (out_has_dst),
  .out_phys_dst(out_phys_dst),
  .int_empty   (pool_empty[0]),
  .fp_empty    (pool_empty[1]),
  .int_cnt     (pool_cnt[0]),
  .fp_cnt      (pool_cnt[1])
);

// File: tb/rename_map_bench.sv
`timescale 1ns/1ps
module rename_map_bench;
  localparam int ARCH = 32;
  localparam int PHYS = 48;
  localparam int AW = $clog2(ARCH);
  localparam int PW = $clog2(PHYS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_fp = 1'b0, in_has_dst = 1'b0;
  logic [AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic rel_valid = 1'b0, rel_fp = 1'b0;
  logic [PW-1:0] rel_phys = '0;
  logic in_ready, out_valid, out_fp, out_has_dst;
  logic [PW-1:0] out_phys_a, out_phys_b, out_phys_dst;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int map_m [2][ARCH];
  int fq [2][$];
  int pend [2][$];

  always #4 clk = ~clk;

  rename_map #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u_rename_map (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fp(in_fp), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_has_dst(in_has_dst), .in_dst(in_dst), .rel_valid(rel_valid),
    .rel_fp(rel_fp), .rel_phys(rel_phys), .out_valid(out_valid),
    .out_fp(out_fp), .out_phys_a(out_phys_a), .out_phys_b(out_phys_b),
    .out_has_dst(out_has_dst), .out_phys_dst(out_phys_dst));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int p = 0; p < 2; p++) begin
      fq[p].delete();
      pend[p].delete();
      for (int i = 0; i < ARCH; i++) map_m[p][i] = i;
      for (int i = ARCH; i < PHYS; i++) fq[p].push_back(i);
    end
  endfunction

  // One cycle: drive, check ready, update model, check registered outputs.
  task automatic step(bit v, bit fp, int a, int b, bit hd, int d,
                      bit rv, bit rfp, int rp, string tag);
    int ea, eb, ed;
    bit fire;
    @(negedge clk);
    in_valid = v; in_fp = fp; in_src_a = AW'(a); in_src_b = AW'(b);
    in_has_dst = hd; in_dst = AW'(d);
    rel_valid = rv; rel_fp = rfp; rel_phys = PW'(rp);
    #1;
    chk(in_ready == (fq[fp].size() > 0), {tag, " ready (R6)"},
        int'(in_ready), int'(fq[fp].size() > 0));
    fire = v && (fq[fp].size() > 0);
    ea = map_m[fp][a];
    eb = map_m[fp][b];
    ed = 0;
    if (fire && hd) begin
      ed = fq[fp].pop_front();
      pend[fp].push_back(map_m[fp][d]);
      map_m[fp][d] = ed;
    end
    if (rv) fq[rfp].push_back(rp);
    @(posedge clk);
    #2;
    chk(out_valid == fire, {tag, " out_valid (R9)"}, int'(out_valid), int'(fire));
    if (fire) begin
      chk(out_fp == fp, {tag, " pool"}, int'(out_fp), int'(fp));
      chk(int'(out_phys_a) == ea, {tag, " src a"}, int'(out_phys_a), ea);
      chk(int'(out_phys_b) == eb, {tag, " src b"}, int'(out_phys_b), eb);
      chk(out_has_dst == hd, {tag, " has dst"}, int'(out_has_dst), int'(hd));
      chk(int'(out_phys_dst) == ed, {tag, " dst"}, int'(out_phys_dst), ed);
    end
    in_valid = 1'b0;
    rel_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p1, p2, p3;
    void'($urandom(32'd7411));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);

    // R1 identity map after reset, both pools
    for (int i = 0; i < 4; i++) step(1, 0, i, ARCH - 1 - i, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 2; i++) step(1, 1, i + 7, i, 0, 0, 0, 0, 0, "R1");
    // R1 first allocation ARCH, then R2 read it back
    step(1, 0, 1, 2, 1, 5, 0, 0, 0, "R1");
    step(1, 0, 5, 4, 0, 0, 0, 0, 0, "R2");
    // R3 read and write of same register
    step(1, 0, 5, 5, 1, 5, 0, 0, 0, "R3");
    // R4 no destination: no allocation, map unchanged
    step(1, 0, 3, 5, 0, 5, 0, 0, 0, "R4");
    step(1, 0, 5, 6, 1, 6, 0, 0, 0, "R4");
    // R5 separate pools
    step(1, 1, 5, 5, 1, 5, 0, 0, 0, "R5");
    step(1, 1, 5, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 5, 6, 0, 0, 0, 0, 0, "R5");
    // R6 drain the integer pool, then stall
    while (fq[0].size() > 0) step(1, 0, 0, 1, 1, fq[0].size() % ARCH, 0, 0, 0, "R6");
    step(1, 0, 2, 3, 1, 9, 0, 0, 0, "R6");
    p1 = pend[0].pop_front();
    step(1, 0, 2, 3, 1, 9, 1, 0, p1, "R6");
    step(1, 0, 2, 9, 1, 9, 0, 0, 0, "R6");
    // R8 release and allocate in the same cycle with entries present
    p1 = pend[0].pop_front();
    p2 = pend[0].pop_front();
    p3 = pend[0].pop_front();
    step(0, 0, 0, 0, 0, 0, 1, 0, p1, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 0, p2, "R8");
    step(1, 0, 9, 4, 1, 4, 1, 0, p3, "R8");
    step(1, 0, 4, 9, 1, 10, 0, 0, 0, "R8");
    step(1, 0, 10, 4, 1, 11, 0, 0, 0, "R7");
    step(1, 0, 11, 11, 0, 0, 0, 0, 0, "R8");

    // Random traffic in both pools with releases of displaced mappings
    for (int n = 0; n < 4000; n++) begin
      bit v, fp, hd, rv, rfp;
      int rp;
      v = ($urandom % 4) != 0;
      fp = $urandom % 2;
      hd = ($urandom % 4) != 0;
      rfp = $urandom % 2;
      rv = (($urandom % 3) != 0) && (pend[rfp].size() > 0);
      rp = 0;
      if (rv) begin
        int k;
        k = (pend[rfp].size() > 1) ? int'($urandom % 2) : 0;
        rp = pend[rfp][k];
        pend[rfp].delete(k);
      end
      step(v, fp, $urandom % ARCH, $urandom % ARCH, hd, $urandom % ARCH,
           rv, rfp, rp, "R2/R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule